// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block divides a fast input clock by an integer N and shapes the output so that its high time is set in steps of half an input clock period. One output period is N input cycles long, which is 2N half-cycles. The high-time setting H gives the number of those half-cycles during which the output is high, and the remaining 2N−H half-cycles form the low phase. The duty-cycle step is therefore 50%/N. An odd H ends the high phase on a falling input edge. This is done with a counter on the rising edge plus a copy retimed on the falling edge.

The divide value, the high time and a 50%-only request are taken up only at a period boundary, so a setting changed mid-period never makes a runt pulse. A setting that cannot be produced is not obeyed. Instead a registered error flag goes high and the output falls back to a safe shape. The enable input forces the output low and restarts the period. A divide value of one passes the input clock straight through.

Top module: `dutydiv_top`

## Requirements
- R1: For 2 ≤ N ≤ 512 and a legal H, each output period lasts N input cycles, with high time H half-cycles and low time 2N−H half-cycles. The output starts the period high.
- R2: An odd H makes the high phase end on a falling edge of the input clock, half a cycle after a rising edge. H=1 gives a single half-cycle pulse.
- R3: H is legal for 1 ≤ H ≤ 2N−2. For H=0 or H > 2N−2, cfg_err reads 1 and the output runs at 50%, with high time N half-cycles.
- R4: While fifty_only is 1 and N is legal, the high time is N half-cycles whatever H holds, and cfg_err reads 0.
- R5: With en at 0 the output is 0 from one input cycle after en falls until en rises again. On rising en a fresh period begins with its high phase.
- R6: While rst is 1, clk_out and cfg_err are 0. At the first rising input edge with rst at 0 and en at 1, a period starts and clk_out goes high at that edge.
- R7: N=1 passes the input clock to clk_out, gated by en. H is ignored and cfg_err reads 0.
- R8: N=0 or N > 512 sets cfg_err to 1 and divides by 2 at 50%, with high time 2 half-cycles and low time 2 half-cycles.
- R9: N, H and fifty_only are captured only at a period boundary. After a mid-period change, every output period has wholly the old shape or wholly the new shape.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Output enable; low forces clk_out to 0 and restarts the period |
| div_n | input | 10 | Divide value N |
| high_h | input | 11 | High time H in half input cycles |
| fifty_only | input | 1 | Forces a 50% output regardless of H |
| clk_out | output | 1 | Divided, duty-shaped clock |
| cfg_err | output | 1 | Captured setting was illegal and a fallback is in use |

## Verification
The assertions assume that div_n, high_h and fifty_only settle before the rising input edge that may capture them. They also assume that rst is held high from time zero until at least one falling edge has passed. The stimulus meets both conditions: it changes every input half a cycle away from a rising edge, and it drops en before loading a new setting into an idle divider. The mid-period change test alters high_h on a falling edge, so the capture question is settled only by the period boundary.

// File: rtl/dutydiv_pkg.sv
package dutydiv_pkg;

  // Output path selected for the captured setting.
  typedef enum logic {
    OUT_DIVIDE = 1'b0,
    OUT_BYPASS = 1'b1
  } out_mode_e;

endpackage

// File: rtl/dutydiv_cfg.sv
// Resolves the requested divide/high-time setting into the values the
// counter will actually use, with legality checks and fallbacks.
module dutydiv_cfg
  import dutydiv_pkg::*;
#(
  parameter int MAX_DIV = 512,
  parameter int NW      = 10,
  parameter int HW      = 11
) (
  input  logic [NW-1:0] div_n,
  input  logic [HW-1:0] high_h,
  input  logic          fifty_only,
  output logic [NW-1:0] n_eff,
  output logic [NW-1:0] hf_eff,
  output logic          odd_eff,
  output out_mode_e     mode_eff,
  output logic          err_eff
);

  localparam logic [NW-1:0] N_FALLBACK = NW'(2);

  logic          n_bad;
  logic          h_bad;
  logic          bypass;
  logic [HW-1:0] n_wide;
  logic [HW-1:0] h_lim;
  logic [HW-1:0] h_sel;

  always_comb begin
    bypass   = (div_n == NW'(1));
    n_bad    = (div_n == '0) || (int'(div_n) > MAX_DIV);
    n_eff    = n_bad ? N_FALLBACK : div_n;
    n_wide   = HW'(n_eff);
    // Largest legal high time: two half-cycles short of the full period.
    h_lim    = (n_wide << 1) - HW'(2);
    h_bad    = !bypass && !n_bad && !fifty_only &&
               ((high_h == '0) || (high_h > h_lim));
    h_sel    = (n_bad || fifty_only || h_bad || bypass) ? n_wide : high_h;
    hf_eff   = NW'(h_sel >> 1);
    odd_eff  = h_sel[0];
    mode_eff = bypass ? OUT_BYPASS : OUT_DIVIDE;
    err_eff  = n_bad || h_bad;
  end

endmodule

// File: rtl/dutydiv_phase.sv
// Rising-edge period counter. Captures the resolved setting at each period
// boundary and produces the full-cycle high phase and the odd-tail marker.
module dutydiv_phase
  import dutydiv_pkg::*;
#(
  parameter int NW = 10
) (
  input  logic          clk_in,
  input  logic          rst,
  input  logic          en,
  input  logic [NW-1:0] n_eff,
  input  logic [NW-1:0] hf_eff,
  input  logic          odd_eff,
  input  out_mode_e     mode_eff,
  input  logic          err_eff,
  output logic          q_pos,
  output logic          q_last,
  output logic          run,
  output logic          wrap,
  output logic [NW-1:0] cnt,
  output logic [NW-1:0] n_r,
  output logic [NW-1:0] hf_r,
  output out_mode_e     mode_r,
  output logic          err_r
);

  logic          odd_r;
  logic          load;
  logic [NW-1:0] hf_u;
  logic          odd_u;
  out_mode_e     mode_u;
  logic [NW-1:0] cnt_nx;
  logic [NW:0]   hi_end;

  always_comb begin
    wrap   = run && (cnt == n_r - NW'(1));
    load   = !run || wrap;
    hf_u   = load ? hf_eff   : hf_r;
    odd_u  = load ? odd_eff  : odd_r;
    mode_u = load ? mode_eff : mode_r;
    cnt_nx = load ? '0 : cnt + NW'(1);
    // An odd tail keeps the rising-edge phase high for one more cycle;
    // the falling-edge retimer then cuts that cycle in half.
    hi_end = {1'b0, hf_u} + (NW+1)'(odd_u);
  end

  always_ff @(posedge clk_in) begin
    if (rst) begin
      run    <= 1'b0;
      cnt    <= '0;
      n_r    <= '0;
      hf_r   <= '0;
      odd_r  <= 1'b0;
      mode_r <= OUT_DIVIDE;
      err_r  <= 1'b0;
      q_pos  <= 1'b0;
      q_last <= 1'b0;
    end else if (!en) begin
      run    <= 1'b0;
      cnt    <= '0;
      q_pos  <= 1'b0;
      q_last <= 1'b0;
    end else begin
      run <= 1'b1;
      cnt <= cnt_nx;
      if (load) begin
        n_r    <= n_eff;
        hf_r   <= hf_eff;
        odd_r  <= odd_eff;
        mode_r <= mode_eff;
        err_r  <= err_eff;
      end
      q_pos  <= (mode_u == OUT_DIVIDE) && ({1'b0, cnt_nx} < hi_end);
      q_last <= (mode_u == OUT_DIVIDE) && odd_u && (cnt_nx == hf_u);
    end
  end

endmodule

// File: rtl/dutydiv_edge.sv
// Falling-edge retiming and output combination. All select signals change
// while the input clock is in the opposite phase, so the output has no
// zero-width pulses.
module dutydiv_edge (
  input  logic clk_in,
  input  logic rst,
  input  logic q_pos,
  input  logic q_last,
  input  logic bypass_on,
  output logic clk_out
);

  logic ext_late;
  logic gate;

  always_ff @(negedge clk_in) begin
    if (rst) begin
      ext_late <= 1'b0;
      gate     <= 1'b0;
    end else begin
      ext_late <= q_last;
      gate     <= bypass_on;
    end
  end

  assign clk_out = gate ? clk_in : (q_pos & ~ext_late);

endmodule

// File: rtl/dutydiv_top.sv
module dutydiv_top
  import dutydiv_pkg::*;
#(
  parameter int MAX_DIV = 512,
  localparam int NW     = $clog2(MAX_DIV + 1),
  localparam int HW     = NW + 1
) (
  input  logic          clk_in,
  input  logic          rst,
  input  logic          en,
  input  logic [NW-1:0] div_n,
  input  logic [HW-1:0] high_h,
  input  logic          fifty_only,
  output logic          clk_out,
  output logic          cfg_err
);

  logic [NW-1:0] n_eff;
  logic [NW-1:0] hf_eff;
  logic          odd_eff;
  out_mode_e     mode_eff;
  logic          err_eff;

  logic          q_pos;
  logic          q_last;
  logic          run;
  logic          wrap;
  logic [NW-1:0] cnt;
  logic [NW-1:0] n_r;
  logic [NW-1:0] hf_r;
  out_mode_e     mode_r;
  logic          bypass_on;

  dutydiv_cfg #(.MAX_DIV(MAX_DIV), .NW(NW), .HW(HW)) u_cfg (
    .div_n      (div_n),
    .high_h     (high_h),
    .fifty_only (fifty_only),
    .n_eff      (n_eff),
    .hf_eff     (hf_eff),
    .odd_eff    (odd_eff),
    .mode_eff   (mode_eff),
    .err_eff    (err_eff)
  );

  dutydiv_phase #(.NW(NW)) u_phase (
    .clk_in   (clk_in),
    .rst      (rst),
    .en       (en),
    .n_eff    (n_eff),
    .hf_eff   (hf_eff),
    .odd_eff  (odd_eff),
    .mode_eff (mode_eff),
    .err_eff  (err_eff),
    .q_pos    (q_pos),
    .q_last   (q_last),
    .run      (run),
    .wrap     (wrap),
    .cnt      (cnt),
    .n_r      (n_r),
    .hf_r     (hf_r),
    .mode_r   (mode_r),
    .err_r    (cfg_err)
  );

  assign bypass_on = run && (mode_r == OUT_BYPASS);

  dutydiv_edge u_edge (
    .clk_in    (clk_in),
    .rst       (rst),
    .q_pos     (q_pos),
    .q_last    (q_last),
    .bypass_on (bypass_on),
    .clk_out   (clk_out)
  );

endmodule

// File: rtl/dutydiv_chk.sv
module dutydiv_chk
  import dutydiv_pkg::*;
#(
  parameter int NW = 10
) (
  input logic          clk_in,
  input logic          rst,
  input logic          en,
  input logic          clk_out,
  input logic          cfg_err,
  input logic          run,
  input logic          wrap,
  input logic          q_last,
  input logic [NW-1:0] cnt,
  input logic [NW-1:0] n_r,
  input logic [NW-1:0] hf_r,
  input out_mode_e     mode_r
);

  assert_off_when_disabled_R5: assert property (@(posedge clk_in) disable iff (rst)
    (!en && $past(!en)) |-> !clk_out);

  assert_reset_clears_R6: assert property (@(posedge clk_in)
    rst |=> (!clk_out && !cfg_err));

  assert_cnt_in_period_R1: assert property (@(posedge clk_in) disable iff (rst)
    run |-> (cnt < n_r));

  assert_latch_at_boundary_R9: assert property (@(posedge clk_in) disable iff (rst)
    ($past(run) && !$past(wrap)) |-> ($stable(n_r) && $stable(hf_r)));

  assert_odd_tail_leaves_low_R2: assert property (@(posedge clk_in) disable iff (rst)
    q_last |-> (cnt != n_r - NW'(1)));

  assert_bypass_no_err_R7: assert property (@(posedge clk_in) disable iff (rst)
    (mode_r == OUT_BYPASS) |-> !cfg_err);

endmodule

bind dutydiv_top dutydiv_chk #(.NW(NW)) u_chk (
  .clk_in  (clk_in),
  .rst     (rst),
  .en      (en),
  .clk_out (clk_out),
  .cfg_err (cfg_err),
  .run     (run),
  .wrap    (wrap),
  .q_last  (q_last),
  .cnt     (cnt),
  .n_r     (n_r),
  .hf_r    (hf_r),
  .mode_r  (mode_r)
);

// File: tb/dutydiv_top_tb.sv
module dutydiv_top_tb;

  localparam int CLK_P = 10;
  localparam int HALF  = CLK_P / 2;

  typedef struct {
    int    hi;
    int    lo;
    bit    err;
    string tag;
  } exp_t;

  logic        clk_in = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [9:0]  div_n = 10'd4;
  logic [10:0] high_h = 11'd3;
  logic        fifty_only = 1'b0;
  logic        clk_out;
  logic        cfg_err;

  int   n_chk = 0;
  int   n_err = 0;
  int   pending = 0;
  exp_t sb_q[$];

  always #(HALF) clk_in = ~clk_in;

  dutydiv_top u_dut (
    .clk_in     (clk_in),
    .rst        (rst),
    .en         (en),
    .div_n      (div_n),
    .high_h     (high_h),
    .fifty_only (fifty_only),
    .clk_out    (clk_out),
    .cfg_err    (cfg_err)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: compute the expected shape from the requirements and queue it.
  task automatic run_case(int n, int h, bit f, string tag);
    exp_t e;
    int   nn;
    int   hh;
    bit   er;
    er = 1'b0;
    if (n == 1) begin
      e.hi = HALF; e.lo = HALF; e.err = 1'b0;
    end else begin
      if (n == 0 || n > 512) begin
        nn = 2; hh = 2; er = 1'b1;
      end else if (f) begin
        nn = n; hh = n;
      end else if (h < 1 || h > 2*n - 2) begin
        nn = n; hh = n; er = 1'b1;
      end else begin
        nn = n; hh = h;
      end
      e.hi = hh * HALF; e.lo = (2*nn - hh) * HALF; e.err = er;
    end
    e.tag = tag;
    @(negedge clk_in);
    en = 1'b0;
    repeat (3) @(negedge clk_in);
    div_n = 10'(n); high_h = 11'(h); fifty_only = f;
    sb_q.push_back(e);
    pending++;
    @(negedge clk_in);
    en = 1'b1;
    wait (pending == 0);
  endtask

  // Monitor: measure the second full period after enable and compare.
  always begin
    longint t0, t1, t2;
    exp_t   e;
    wait (pending > 0);
    e = sb_q[0];
    @(posedge clk_out);
    @(posedge clk_out); t0 = $time;
    @(negedge clk_out); t1 = $time;
    @(posedge clk_out); t2 = $time;
    #1;
    chk((t1 - t0) == e.hi, e.tag, "high time", t1 - t0, e.hi);
    chk((t2 - t1) == e.lo, e.tag, "low time", t2 - t1, e.lo);
    chk(cfg_err == e.err, e.tag, "cfg_err", cfg_err, e.err);
    void'(sb_q.pop_front());
    pending--;
  end

  initial begin
    #(CLK_P * 150000);
    n_err++;
    $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    longint ta, tb, tc;
    // R6: reset holds the output and flag low, even with en high.
    en = 1'b1;
    repeat (3) @(negedge clk_in);
    chk(clk_out == 1'b0, "R6", "clk_out in reset", clk_out, 0);
    chk(cfg_err == 1'b0, "R6", "cfg_err in reset", cfg_err, 0);
    #2;
    chk(clk_out == 1'b0, "R6", "clk_out in reset late", clk_out, 0);
    @(negedge clk_in);
    rst = 1'b0;
    // R6: the period starts at the first edge after release (N=4, H=3).
    @(posedge clk_in); ta = $time;
    #1;
    chk(clk_out == 1'b1, "R6", "high at first edge", clk_out, 1);
    @(negedge clk_out); tb = $time;
    chk((tb - ta) == 3*HALF, "R6", "first high time", tb - ta, 3*HALF);

    // R1 and R2: every legal H for several N.
    run_case(2, 1, 1'b0, "R2"); run_case(2, 2, 1'b0, "R1");
    for (int h = 1; h <= 4; h++)  run_case(3, h, 1'b0, (h % 2) ? "R2" : "R1");
    for (int h = 1; h <= 8; h++)  run_case(5, h, 1'b0, (h % 2) ? "R2" : "R1");
    for (int h = 1; h <= 18; h++) run_case(10, h, 1'b0, (h % 2) ? "R2" : "R1");
    run_case(512, 1, 1'b0, "R2");
    run_case(512, 1022, 1'b0, "R1");
    run_case(512, 511, 1'b0, "R2");

    // R3: out-of-range high times fall back to 50% with the flag set.
    run_case(10, 0, 1'b0, "R3");
    run_case(10, 19, 1'b0, "R3");
    run_case(10, 20, 1'b0, "R3");
    run_case(3, 5, 1'b0, "R3");

    // R4: 50%-only mode overrides H without raising the flag.
    run_case(10, 3, 1'b1, "R4");
    run_case(7, 0, 1'b1, "R4");

    // R7: bypass for N=1, H ignored.
    run_case(1, 7, 1'b0, "R7");

    // R8: illegal divide values.
    run_case(0, 3, 1'b0, "R8");
    run_case(513, 3, 1'b0, "R8");

    // R5: disabled output stays low.
    @(negedge clk_in);
    en = 1'b0;
    repeat (2) @(negedge clk_in);
    for (int i = 0; i < 8; i++) begin
      #(HALF / 2);
      chk(clk_out == 1'b0, "R5", "clk_out while disabled", clk_out, 0);
      #(HALF - HALF / 2);
    end

    // R5: disable in bypass mode too.
    run_case(1, 0, 1'b0, "R7");
    @(negedge clk_in);
    en = 1'b0;
    repeat (2) @(negedge clk_in);
    for (int i = 0; i < 4; i++) begin
      #(HALF / 2);
      chk(clk_out == 1'b0, "R5", "bypass clk_out while disabled", clk_out, 0);
      #(HALF - HALF / 2);
    end

    // R9: change H mid-period; each period is wholly old or wholly new.
    div_n = 10'd8; high_h = 11'd4; fifty_only = 1'b0;
    @(negedge clk_in);
    en = 1'b1;
    repeat (19) @(negedge clk_in);
    high_h = 11'd12;
    for (int p = 0; p < 4; p++) begin
      @(posedge clk_out); ta = $time;
      @(negedge clk_out); tb = $time;
      @(posedge clk_out); tc = $time;
      chk(((tb - ta) == 4*HALF) || ((tb - ta) == 12*HALF), "R9",
          "high time old or new", tb - ta, 12*HALF);
      chk((tc - ta) == 16*HALF, "R9", "period length", tc - ta, 16*HALF);
    end
    chk((tb - ta) == 12*HALF, "R9", "new shape in effect", tb - ta, 12*HALF);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule